// File: doc/BRIEF.md
# Register Write Busy Guard

This block sits on the write path into a peripheral's control registers. Most writes go straight through. Writes to a set of sensitive registers are held until the peripheral reports that it is idle. The address being written decides what "idle" means.

Writes to the command and transfer setup registers wait for a command-busy flag to drop, provided the peripheral has that flag. If the flag is not present, they wait for a divider-enable flag to rise instead. Writes to the clock-control register always wait for the divider-enable flag.

The guard samples the idle condition once per poll interval. The interval is a parameterised number of clock cycles. If the peripheral is still busy after a parameterised number of polls, the held write is discarded and a one-cycle error pulse is raised. Only one write is held at a time. While a write is held, the request port is stalled.

Top module: `wr_busy_guard`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and both `wr_valid` and `drop_err` are 0.
- R2: A write to an unguarded address (any address above 0x08) is accepted when `req_ready` is 1. It appears on `wr_valid`/`wr_addr`/`wr_data` one cycle after acceptance.
- R3: Addresses 0x00 to 0x07 form the command group. When `cmd_flag_avail` is 1, a write to this group is issued only from a poll that sees `cmd_busy` low. `div_en` has no effect on it.
- R4: When `cmd_flag_avail` is 0, a write to the command group is issued only from a poll that sees `div_en` high. `cmd_busy` has no effect on it.
- R5: A write to the clock-control address 0x08 is issued only from a poll that sees `div_en` high, whatever the values of `cmd_flag_avail` and `cmd_busy`.
- R6: A guarded write is accepted at edge E. Polls then happen in the cycles after E, E+P, E+2P and so on, where P is `POLL_INTERVAL`. A write issued from the poll in the cycle after E+kP appears one cycle later.
- R7: If `MAX_POLLS` polls in a row all see the peripheral busy, the held write is dropped. `drop_err` is high for exactly one cycle, one cycle after the last poll, and no write is issued for that request.
- R8: `req_ready` is 0 from the cycle after a guarded write is accepted until that write is issued or dropped.
- R9: `wr_valid` and `drop_err` are never high in the same cycle. Every accepted request produces exactly one of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_flag_avail | input | 1 | Peripheral has a command-busy flag |
| cmd_busy | input | 1 | Command-busy flag, high while busy |
| div_en | input | 1 | Divider-enable flag, high while idle |
| req_valid | input | 1 | Write request present |
| req_addr | input | 8 | Request register address |
| req_data | input | DATA_W | Request write data |
| req_ready | output | 1 | Guard can accept a request |
| wr_valid | output | 1 | Write strobe to the register file |
| wr_addr | output | 8 | Register address of the issued write |
| wr_data | output | DATA_W | Data of the issued write |
| drop_err | output | 1 | One-cycle pulse when a held write times out |

## Verification
The bench builds the guard with `POLL_INTERVAL` set to 4 and `MAX_POLLS` set to 5, so a full timeout window is 17 cycles.

These small values make the individual poll instants reachable. Flags are released at chosen cycles inside a wait, so that the write lands exactly on the next poll. The boundaries can also be hit: release in time for the last poll gives a write, and release one cycle too late gives a drop.

Every guarded address is also exercised under each polarity choice, to show that the flag which should not matter really does not.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

    localparam int unsigned ADDR_W = 8;

    // Guarded register offsets; the command group is contiguous
    localparam logic [ADDR_W-1:0] REG_CMD_FIRST = 8'h00;
    localparam logic [ADDR_W-1:0] REG_CMD_LAST  = 8'h07;
    localparam logic [ADDR_W-1:0] REG_CLK_CTRL  = 8'h08;

    typedef enum logic [1:0] {
        CLS_PASS = 2'd0,
        CLS_CMD  = 2'd1,
        CLS_CLK  = 2'd2
    } wclass_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } gstate_e;

    function automatic wclass_e classify(input logic [ADDR_W-1:0] a);
        if (a >= REG_CMD_FIRST && a <= REG_CMD_LAST) return CLS_CMD;
        if (a == REG_CLK_CTRL)                       return CLS_CLK;
        return CLS_PASS;
    endfunction

    // Idle test: command group prefers the busy flag when it exists
    function automatic logic idle_for(input wclass_e c, input logic flag_avail,
                                      input logic busy, input logic dive);
        if (c == CLS_CMD && flag_avail) return !busy;
        return dive;
    endfunction

endpackage

// File: rtl/wguard_poll_timer.sv
module wguard_poll_timer #(
    parameter int unsigned POLL_INTERVAL = 50,
    parameter int unsigned MAX_POLLS     = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic poll_now,
    output logic last_poll
);
    localparam int unsigned TW = $clog2(POLL_INTERVAL + 1);
    localparam int unsigned PW = $clog2(MAX_POLLS + 1);

    logic [TW-1:0] tick_q;
    logic [PW-1:0] polls_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_q  <= '0;
            polls_q <= '0;
        end else begin
            tick_q <= (tick_q == TW'(POLL_INTERVAL - 1)) ? '0 : tick_q + 1'b1;
            if (tick_q == '0) polls_q <= polls_q + 1'b1;
        end
    end

    assign poll_now  = run && (tick_q == '0);
    assign last_poll = (polls_q == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/wguard_hold.sv
module wguard_hold
    import wguard_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  wclass_e           in_cls,
    output logic [ADDR_W-1:0] h_addr,
    output logic [DATA_W-1:0] h_data,
    output wclass_e           h_cls
);
    always_ff @(posedge clk) begin
        if (rst) begin
            h_addr <= '0;
            h_data <= '0;
            h_cls  <= CLS_PASS;
        end else if (load) begin
            h_addr <= in_addr;
            h_data <= in_data;
            h_cls  <= in_cls;
        end
    end
endmodule

// File: rtl/wr_busy_guard.sv
module wr_busy_guard
    import wguard_pkg::*;
#(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned POLL_INTERVAL = 50,
    parameter int unsigned MAX_POLLS     = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_flag_avail,
    input  logic              cmd_busy,
    input  logic              div_en,
    input  logic              req_valid,
    input  logic [7:0]        req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              wr_valid,
    output logic [7:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drop_err
);
    gstate_e           state_q;
    wclass_e           req_cls;
    logic              accept, take_guarded;
    logic              poll_now, last_poll, idle_ok;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    wclass_e           h_cls;

    assign req_ready    = (state_q == ST_IDLE);
    assign req_cls      = classify(req_addr);
    assign accept       = req_valid && req_ready;
    assign take_guarded = accept && (req_cls != CLS_PASS);

    wguard_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .load(take_guarded),
        .in_addr(req_addr), .in_data(req_data), .in_cls(req_cls),
        .h_addr(h_addr), .h_data(h_data), .h_cls(h_cls)
    );

    wguard_poll_timer #(
        .POLL_INTERVAL(POLL_INTERVAL), .MAX_POLLS(MAX_POLLS)
    ) u_timer (
        .clk(clk), .rst(rst), .run(state_q == ST_HOLD),
        .poll_now(poll_now), .last_poll(last_poll)
    );

    assign idle_ok = idle_for(h_cls, cmd_flag_avail, cmd_busy, div_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            drop_err <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            drop_err <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && req_cls == CLS_PASS) begin
                        wr_valid <= 1'b1;
                        wr_addr  <= req_addr;
                        wr_data  <= req_data;
                    end else if (take_guarded) begin
                        state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (poll_now) begin
                        if (idle_ok) begin
                            wr_valid <= 1'b1;
                            wr_addr  <= h_addr;
                            wr_data  <= h_data;
                            state_q  <= ST_IDLE;
                        end else if (last_poll) begin
                            drop_err <= 1'b1;
                            state_q  <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wr_busy_guard_chk.sv
module wr_busy_guard_chk
    import wguard_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_flag_avail,
    input logic              cmd_busy,
    input logic              div_en,
    input logic              req_valid,
    input logic [7:0]        req_addr,
    input logic [DATA_W-1:0] req_data,
    input logic              req_ready,
    input logic              wr_valid,
    input logic [7:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              drop_err
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !wr_valid && !drop_err));

    p_pass_next_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && classify(req_addr) == CLS_PASS)
        |=> (wr_valid && wr_addr == $past(req_addr) && wr_data == $past(req_data)));

    p_cmd_busy_low_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !$past(req_ready) && classify(wr_addr) == CLS_CMD && $past(cmd_flag_avail))
        |-> !$past(cmd_busy));

    p_cmd_div_high_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !$past(req_ready) && classify(wr_addr) == CLS_CMD && !$past(cmd_flag_avail))
        |-> $past(div_en));

    p_clk_div_high_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !$past(req_ready) && classify(wr_addr) == CLS_CLK)
        |-> $past(div_en));

    p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
        drop_err |=> !drop_err);

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && classify(req_addr) != CLS_PASS) |=> !req_ready);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && drop_err));
endmodule

bind wr_busy_guard wr_busy_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_flag_avail(cmd_flag_avail), .cmd_busy(cmd_busy),
    .div_en(div_en), .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_ready(req_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .drop_err(drop_err)
);

// File: tb/test_wr_busy_guard.sv
module test_wr_busy_guard;
    localparam int P  = 4;
    localparam int M  = 5;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic cmd_flag_avail = 1'b0, cmd_busy = 1'b0, div_en = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, wr_valid, drop_err;
    logic [7:0] wr_addr;
    logic [DW-1:0] wr_data;

    wr_busy_guard #(.DATA_W(DW), .POLL_INTERVAL(P), .MAX_POLLS(M)) i_wr_busy_guard (
        .clk(clk), .rst(rst), .cmd_flag_avail(cmd_flag_avail), .cmd_busy(cmd_busy),
        .div_en(div_en), .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .drop_err(drop_err)
    );

    int pcnt = 0;
    always @(posedge clk) pcnt <= pcnt + 1;

    typedef struct {
        bit          is_err;
        logic [7:0]  a;
        logic [DW-1:0] d;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t got;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each output event
    always @(negedge clk) begin
        if (!rst && (wr_valid || drop_err)) begin
            n_cmp++;
            if (wr_valid && drop_err) begin
                n_bad++;
                $display("FAIL R9: actual write+drop together expected one of them");
            end else if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R9: actual event err=%0d addr=%h at %0d expected none",
                         drop_err, wr_addr, pcnt);
            end else begin
                got = q.pop_front();
                if (got.is_err != drop_err || got.cyc != pcnt ||
                    (!got.is_err && (got.a != wr_addr || got.d != wr_data))) begin
                    n_bad++;
                    $display("FAIL %s: actual err=%0d addr=%h data=%h cyc=%0d expected err=%0d addr=%h data=%h cyc=%0d",
                             got.tag, drop_err, wr_addr, wr_data, pcnt,
                             got.is_err, got.a, got.d, got.cyc);
                end
            end
        end
    end

    // idle_at: wait-cycle index where the flag turns idle (-1: never); which 0 clears cmd_busy, 1 sets div_en
    task automatic go(input logic [7:0] a, input logic [DW-1:0] d, input int idle_at,
                      input int which, input string tag);
        exp_t e;
        int n, k, due;
        bit guarded;
        guarded = (a <= 8'h08);
        @(negedge clk);
        n = pcnt;
        req_valid = 1'b1; req_addr = a; req_data = d;
        if (!guarded) begin
            e.is_err = 0; due = n + 1;
        end else if (idle_at < 0) begin
            e.is_err = 1; due = n + 2 + (M - 1) * P;
        end else begin
            k = (idle_at + P - 1) / P;
            if (k < M) begin e.is_err = 0; due = n + 2 + k * P; end
            else begin e.is_err = 1; due = n + 2 + (M - 1) * P; end
        end
        e.a = a; e.d = d; e.cyc = due; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (guarded) chk(req_ready == 1'b0, "R8", int'(req_ready), 0);
        if (guarded && idle_at >= 0) begin
            repeat (idle_at) @(negedge clk);
            if (which == 0) cmd_busy = 1'b0; else div_en = 1'b1;
        end
        while (pcnt < due + 1) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && !wr_valid && !drop_err, "R1", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && !wr_valid && !drop_err, "R1", int'(req_ready), 1);

        // R2: unguarded pass-through
        go(8'h20, 16'hA5A5, 0, 0, "R2");
        go(8'h09, 16'h0009, 0, 0, "R2");
        go(8'hFF, 16'h1234, 0, 0, "R2");

        // R3: flag present, busy low, div_en low ignored
        cmd_flag_avail = 1; cmd_busy = 0; div_en = 0;
        for (int a = 0; a < 8; a++) go(8'(a), 16'(16'h100 + a), 0, 0, "R3");

        // R6/R3: busy clears in wait cycle 6 -> third poll
        cmd_busy = 1; div_en = 1;
        go(8'h05, 16'hBEEF, 6, 0, "R6");

        // R7/R3: busy never clears, div_en high does not help
        cmd_busy = 1; div_en = 1;
        go(8'h07, 16'hDEAD, -1, 0, "R7");

        // R4: flag absent, div_en rises in wait cycle 4
        cmd_flag_avail = 0; cmd_busy = 1; div_en = 0;
        go(8'h03, 16'h0303, 4, 1, "R4");

        // R4: flag absent, busy low ignored -> drop
        cmd_busy = 0; div_en = 0;
        go(8'h06, 16'h0606, -1, 0, "R4");

        // R5: clock control ignores busy low
        cmd_flag_avail = 1; cmd_busy = 0; div_en = 0;
        go(8'h08, 16'h0808, -1, 0, "R5");

        // R5/R7: div_en in time for the last poll
        cmd_busy = 1; div_en = 0;
        go(8'h08, 16'h0818, 16, 1, "R5");

        // R7: one cycle too late -> drop
        div_en = 0;
        go(8'h08, 16'h0817, 17, 1, "R7");

        // R4: same address group under each polarity choice
        cmd_flag_avail = 0; cmd_busy = 1; div_en = 1;
        go(8'h00, 16'h0F0F, 0, 1, "R4");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R9", q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        wait (pcnt > 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end
endmodule